// File: doc/BRIEF.md
# PLL Control Register Block with Lock Timer

This block is the software-visible control face of a single PLL inside a clock controller. A 32-bit register bus writes and reads back a base register and a misc register. The block turns the fields of those registers into decoded divider and control outputs, and it runs a lock timer that counts a once-per-microsecond tick after the PLL is enabled. A read-only status word reports which reference oscillator frequency the board strapped in.

Firmware brings the PLL up in three writes. The first sets the dividers with bypass on and enable off. The second turns enable on. The third clears bypass while leaving the dividers alone. Firmware also reads the base register back and skips this sequence if the enable bit is already set. The block reports a stable flag and an output-source indication. The source is the reference while bypass is set. With bypass clear, the output stays gated low until the lock window has run out, and after that the source is the PLL. The analog loop, the frequency synthesis and the clock multiplexer are not part of this block.

Top module: `pllctl_unit`

## Requirements
- R1: After a synchronous reset, the base and misc registers read as zero, the stable flag is 0 and the source code is 0 (gated).
- R2: The base register is at byte address 0x0 and keeps only these bits: bit 31 (bypass), bit 30 (enable), bit 28 (override), bits 22:20 (post-divider exponent P), bits 17:8 (feedback divider N) and bits 4:0 (input divider M). All other bits read as 0. Read-back mask: 0xD073FF1F.
- R3: The misc register is at byte address 0x4 and keeps only bits 11:8 (charge-pump control) and bits 7:4 (loop-filter control). Read-back mask: 0x00000FF0.
- R4: Byte address 0x8 returns the 2-bit oscillator code in bits 31:30, with all other bits 0. The codes are 0=13 MHz, 1=19.2 MHz, 2=12 MHz and 3=26 MHz. Writes to 0x8 have no effect, and every other address reads as 0.
- R5: The decoded outputs div_m, div_n, div_p, cp_ctl, lf_ctl and base_override always equal the matching stored fields.
- R6: While enable is set, the lock counter advances on each tick_us pulse. pll_stable goes high in the cycle after the LOCK_US-th counted tick (default 300) and stays high while enable stays set.
- R7: A base write that keeps enable set and leaves M, N and P unchanged does not restart the lock count. Dropping bypass is an example of such a write. A base write that keeps enable set and changes M, N or P restarts the count from zero.
- R8: A base write with enable clear zeroes the lock count, so pll_stable is 0 in the following cycle.
- R9: out_src is 1 (reference) whenever bypass is set. With bypass clear it is 2 (PLL) when pll_stable is high, and 0 (gated) otherwise.
- R10: When a restarting base write and a tick_us pulse fall in the same cycle, the restart wins and the count is zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for bus_addr/bus_wdata |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| osc_code | input | 2 | Strapped reference oscillator code |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| pll_stable | output | 1 | Lock window has elapsed while enabled |
| out_src | output | 2 | 0 gated, 1 reference, 2 PLL |
| div_m | output | M_W | Input divider field |
| div_n | output | N_W | Feedback divider field |
| div_p | output | P_W | Post-divider exponent |
| cp_ctl | output | CP_W | Charge-pump control field |
| lf_ctl | output | LF_W | Loop-filter control field |
| base_override | output | 1 | Base override flag |

## Verification
The microsecond tick and a base write can fall on the same clock edge, and the write may restart the count, clear it, or leave it running. The bench provokes this collision in two ways. It changes the dividers while ticks arrive every cycle, and it drops bypass in the middle of a window. Random runs then put writes and ticks together in arbitrary cycles. A behavioural model counts ticks and decides restart or clear from the requirements alone. The bench compares stable, source, decoded fields and read data on every clock, so a restart that loses to the tick, or a bypass drop that restarts the count, shows up as a miscompare at the exact boundary cycle.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;

    localparam int OFF_BASE = 'h0;
    localparam int OFF_MISC = 'h4;
    localparam int OFF_OSC  = 'h8;

    localparam int BIT_BYPASS = 31;
    localparam int BIT_ENABLE = 30;
    localparam int BIT_OVR    = 28;
    localparam int M_LSB      = 0;
    localparam int N_LSB      = 8;
    localparam int P_LSB      = 20;
    localparam int LF_LSB     = 4;
    localparam int CP_LSB     = 8;
    localparam int OSC_LSB    = 30;

    typedef enum logic [1:0] {
        SRC_GATED = 2'd0,
        SRC_REF   = 2'd1,
        SRC_PLL   = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        OSC_13M0 = 2'd0,
        OSC_19M2 = 2'd1,
        OSC_12M0 = 2'd2,
        OSC_26M0 = 2'd3
    } osc_e;

    typedef struct packed {
        logic bypass;
        logic enable;
        logic ovr;
    } base_ctl_t;

    function automatic logic [31:0] field_mask(input int lsb, input int width);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i >= lsb && i < lsb + width) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pllctl_regs.sv
module pllctl_regs
    import pllctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int M_W    = 5,
    parameter int N_W    = 10,
    parameter int P_W    = 3,
    parameter int CP_W   = 4,
    parameter int LF_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        osc_code,
    output base_ctl_t         ctl,
    output logic [M_W-1:0]    div_m,
    output logic [N_W-1:0]    div_n,
    output logic [P_W-1:0]    div_p,
    output logic [CP_W-1:0]   cp_ctl,
    output logic [LF_W-1:0]   lf_ctl,
    output logic              restart,
    output logic              clear
);
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(OFF_BASE);
    localparam logic [ADDR_W-1:0] A_MISC = ADDR_W'(OFF_MISC);
    localparam logic [ADDR_W-1:0] A_OSC  = ADDR_W'(OFF_OSC);
    localparam logic [31:0] DIV_MASK = field_mask(M_LSB, M_W) | field_mask(N_LSB, N_W)
                                     | field_mask(P_LSB, P_W);
    localparam logic [31:0] BASE_MASK = DIV_MASK | field_mask(BIT_BYPASS, 1)
                                      | field_mask(BIT_ENABLE, 1) | field_mask(BIT_OVR, 1);
    localparam logic [31:0] MISC_MASK = field_mask(CP_LSB, CP_W) | field_mask(LF_LSB, LF_W);

    logic [31:0] base_q, misc_q, base_d;
    logic        wr_base, wr_misc;

    assign wr_base = bus_wr && (bus_addr == A_BASE);
    assign wr_misc = bus_wr && (bus_addr == A_MISC);
    assign base_d  = bus_wdata & BASE_MASK;

    // lock timer control derived from the incoming write
    assign clear   = wr_base && !base_d[BIT_ENABLE];
    assign restart = wr_base && base_d[BIT_ENABLE]
                     && (!base_q[BIT_ENABLE] || ((base_d & DIV_MASK) != (base_q & DIV_MASK)));

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            misc_q <= '0;
        end else begin
            if (wr_base) base_q <= base_d;
            if (wr_misc) misc_q <= bus_wdata & MISC_MASK;
        end
    end

    always_comb begin
        case (bus_addr)
            A_BASE:  bus_rdata = base_q;
            A_MISC:  bus_rdata = misc_q;
            A_OSC:   bus_rdata = 32'(osc_code) << OSC_LSB;
            default: bus_rdata = '0;
        endcase
    end

    assign ctl.bypass = base_q[BIT_BYPASS];
    assign ctl.enable = base_q[BIT_ENABLE];
    assign ctl.ovr    = base_q[BIT_OVR];
    assign div_m  = base_q[M_LSB +: M_W];
    assign div_n  = base_q[N_LSB +: N_W];
    assign div_p  = base_q[P_LSB +: P_W];
    assign cp_ctl = misc_q[CP_LSB +: CP_W];
    assign lf_ctl = misc_q[LF_LSB +: LF_W];

    assert_base_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_base |=> (base_q == $past(bus_wdata & BASE_MASK)));
    assert_misc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_misc |=> $stable(misc_q));

endmodule

// File: rtl/pllctl_lock_timer.sv
module pllctl_lock_timer #(
    parameter int LOCK_US = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tick_us,
    input  logic restart,
    input  logic clear,
    output logic stable
);
    localparam int CNT_W = $clog2(LOCK_US + 1);
    localparam logic [CNT_W-1:0] LOCK_C = CNT_W'(LOCK_US);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear || restart) begin
            cnt_q <= '0;
        end else if (enable && tick_us && (cnt_q != LOCK_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stable = enable && (cnt_q == LOCK_C);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0) && !stable);
    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0));
    assert_stable_en_R6: assert property (@(posedge clk) disable iff (rst)
        stable |-> enable);
    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        (enable && tick_us && !restart && !clear && cnt_q != LOCK_C)
        |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOCK_C);

endmodule

// File: rtl/pllctl_src_sel.sv
module pllctl_src_sel
    import pllctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bypass,
    input  logic stable,
    output src_e src
);
    always_comb begin
        if (bypass)      src = SRC_REF;
        else if (stable) src = SRC_PLL;
        else             src = SRC_GATED;
    end

    assert_bypass_ref_R9: assert property (@(posedge clk) disable iff (rst)
        bypass |-> (src == SRC_REF));
    assert_pll_needs_lock_R9: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_PLL) |-> (stable && !bypass));

endmodule

// File: rtl/pllctl_unit.sv
module pllctl_unit
    import pllctl_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int M_W     = 5,
    parameter int N_W     = 10,
    parameter int P_W     = 3,
    parameter int CP_W    = 4,
    parameter int LF_W    = 4,
    parameter int LOCK_US = 300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        osc_code,
    input  logic              tick_us,
    output logic              pll_stable,
    output logic [1:0]        out_src,
    output logic [M_W-1:0]    div_m,
    output logic [N_W-1:0]    div_n,
    output logic [P_W-1:0]    div_p,
    output logic [CP_W-1:0]   cp_ctl,
    output logic [LF_W-1:0]   lf_ctl,
    output logic              base_override
);
    base_ctl_t ctl;
    logic      restart, clear;
    src_e      src;

    pllctl_regs #(
        .ADDR_W(ADDR_W), .M_W(M_W), .N_W(N_W), .P_W(P_W), .CP_W(CP_W), .LF_W(LF_W)
    ) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_code(osc_code),
        .ctl(ctl), .div_m(div_m), .div_n(div_n), .div_p(div_p),
        .cp_ctl(cp_ctl), .lf_ctl(lf_ctl), .restart(restart), .clear(clear)
    );

    pllctl_lock_timer #(.LOCK_US(LOCK_US)) u_timer (
        .clk(clk), .rst(rst), .enable(ctl.enable), .tick_us(tick_us),
        .restart(restart), .clear(clear), .stable(pll_stable)
    );

    pllctl_src_sel u_src (
        .clk(clk), .rst(rst), .bypass(ctl.bypass), .stable(pll_stable), .src(src)
    );

    assign out_src       = src;
    assign base_override = ctl.ovr;

    assert_stable_src_R9: assert property (@(posedge clk) disable iff (rst)
        (pll_stable && !ctl.bypass) |-> (out_src == 2'd2));

endmodule

// File: tb/tb_pllctl_unit.sv
module tb_pllctl_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  osc_code = 2'd0;
    logic        tick_us = 1'b0;
    logic        pll_stable;
    logic [1:0]  out_src;
    logic [4:0]  div_m;
    logic [9:0]  div_n;
    logic [2:0]  div_p;
    logic [3:0]  cp_ctl;
    logic [3:0]  lf_ctl;
    logic        base_override;

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    logic [31:0] base_m = '0;
    logic [31:0] misc_m = '0;
    int          cnt_m  = 0;
    localparam int LOCK = 300;

    always #2 clk = ~clk;

    pllctl_unit dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_code(osc_code),
        .tick_us(tick_us), .pll_stable(pll_stable), .out_src(out_src),
        .div_m(div_m), .div_n(div_n), .div_p(div_p), .cp_ctl(cp_ctl),
        .lf_ctl(lf_ctl), .base_override(base_override)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'h0: return base_m;
            4'h4: return misc_m;
            4'h8: return {osc_code, 30'b0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic compare(input string tag);
        logic st;
        logic [1:0] src;
        st  = base_m[30] && (cnt_m == LOCK);
        src = base_m[31] ? 2'd1 : (st ? 2'd2 : 2'd0);
        chk(tag, "stable", 32'(pll_stable), 32'(st));
        chk(tag, "src", 32'(out_src), 32'(src));
        chk(tag, "rdata", bus_rdata, exp_read(bus_addr));
        chk(tag, "fields", {base_override, div_p, div_n, div_m, cp_ctl, lf_ctl},
            {base_m[28], base_m[22:20], base_m[17:8], base_m[4:0], misc_m[11:8], misc_m[7:4]});
    endtask

    task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] d,
                        input logic tk, input string tag);
        logic [31:0] nb;
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick_us = tk;
        @(posedge clk);
        if (wr && a == 4'h0) begin
            nb = d & 32'hD073FF1F;
            if (!nb[30]) cnt_m = 0;
            else if (!base_m[30] || (nb & 32'h0073FF1F) != (base_m & 32'h0073FF1F)) cnt_m = 0;
            else if (tk && cnt_m < LOCK) cnt_m++;
            base_m = nb;
        end else begin
            if (wr && a == 4'h4) misc_m = d & 32'h00000FF0;
            if (base_m[30] && tk && cnt_m < LOCK) cnt_m++;
        end
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [31:0] base_word(input logic byp, input logic en,
                                              input logic [4:0] m, input logic [9:0] n,
                                              input logic [2:0] p);
        return {byp, en, 1'b0, 1'b0, 5'b0, p, 2'b0, n, 3'b0, m};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1");

        // R2 base read-back mask, R5 decoded fields
        step(1'b1, 4'h0, 32'h2FFF_FFFF, 1'b0, "R2");
        step(1'b0, 4'h0, 32'h0, 1'b0, "R5");
        step(1'b1, 4'h0, 32'h0, 1'b0, "R2");
        // R3 misc mask
        step(1'b1, 4'h4, 32'hFFFF_FFFF, 1'b0, "R3");
        step(1'b0, 4'h4, 32'h0, 1'b0, "R5");
        step(1'b1, 4'h4, 32'h0000_0A50, 1'b0, "R3");
        // R4 oscillator word, unmapped addresses, writes to read-only word
        for (int c = 0; c < 4; c++) begin
            osc_code = 2'(c);
            step(1'b0, 4'h8, 32'h0, 1'b0, "R4");
        end
        step(1'b1, 4'h8, 32'hFFFF_FFFF, 1'b0, "R4");
        step(1'b0, 4'h0, 32'h0, 1'b0, "R4");
        step(1'b1, 4'hC, 32'hFFFF_FFFF, 1'b0, "R4");
        step(1'b0, 4'hC, 32'h0, 1'b0, "R4");
        step(1'b0, 4'h1, 32'h0, 1'b0, "R4");

        // bring-up sequence: bypass only, enable, drop bypass
        step(1'b1, 4'h0, base_word(1'b1, 1'b0, 5'd12, 10'd1000, 3'd1), 1'b1, "R9");
        step(1'b1, 4'h0, base_word(1'b1, 1'b1, 5'd12, 10'd1000, 3'd1), 1'b1, "R6");
        for (int i = 0; i < 150; i++) step(1'b0, 4'h0, 32'h0, 1'b1, "R6");
        step(1'b1, 4'h0, base_word(1'b0, 1'b1, 5'd12, 10'd1000, 3'd1), 1'b1, "R7");
        for (int i = 0; i < 200; i++) step(1'b0, 4'h0, 32'h0, 1'b1, "R6");

        // divider change while ticking: restart beats the tick
        step(1'b1, 4'h0, base_word(1'b0, 1'b1, 5'd12, 10'd999, 3'd1), 1'b1, "R10");
        step(1'b0, 4'h0, 32'h0, 1'b0, "R7");
        // sparse ticks
        for (int i = 0; i < 900; i++) step(1'b0, 4'h4, 32'h0, 1'(i % 3 == 0), "R6");
        // disable clears lock
        step(1'b1, 4'h0, base_word(1'b0, 1'b0, 5'd12, 10'd999, 3'd1), 1'b1, "R8");
        for (int i = 0; i < 5; i++) step(1'b0, 4'h0, 32'h0, 1'b1, "R8");

        // random mix of writes and ticks
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [3:0] a;
            r = int'($urandom % 1000);
            a = 4'(($urandom % 4) * 4);
            osc_code = 2'($urandom % 4);
            if (r < 8)
                step(1'b1, 4'h0, base_word(1'($urandom % 2), 1'($urandom % 8 != 0),
                     5'($urandom % 2), 10'd40, 3'($urandom % 2)) | ($urandom & 32'h1000_0000),
                     1'($urandom % 2), "R9");
            else if (r < 12)
                step(1'b1, 4'h4, $urandom, 1'($urandom % 2), "R3");
            else
                step(1'b0, a, 32'h0, 1'($urandom % 2), "R9");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule